// File: doc/BRIEF.md
# Ethernet PAUSE Flow Controller

This block handles link-level PAUSE flow control for a MAC. On the receive side it takes PAUSE events that the frame parser has already decoded. Each event carries a 16-bit quanta value. The block loads a hold counter from that value. It then stops the transmitter at the next frame boundary until the counter has counted down to zero. The counter moves once per pulse of an external timebase, and each pulse marks one pause quantum of 512 bit times.

On the send side the block compares the receive FIFO level with a programmable threshold. When the FIFO fills up, it asks the frame serialiser to send a PAUSE with a programmable quanta value. It then follows how much of that requested time is still outstanding at the link partner.

A single zero-time enable bit covers both directions:
- On receive, it decides whether an incoming zero-quanta PAUSE cancels a hold or is dropped.
- On send, it decides whether the block sends one zero-quanta PAUSE when the FIFO drains below the threshold before the outstanding time has run out.

The mode inputs are expected to stay fixed while traffic is enabled. A soft reset returns everything to the idle state before reprogramming.

Top module: `pause_flow_ctrl`

## Requirements
- R1: A received PAUSE with non-zero quanta Q loads `hold_time_left` with Q one clock later. It replaces any count that remains. A receive event in the same cycle as a tick takes priority over the tick.
- R2: While `hold_time_left` is non-zero, each `quanta_tick` pulse lowers it by one. `tx_hold` follows the non-zero state of the counter with a delay of one clock, so it drops one clock after the counter reaches zero.
- R3: With `zero_pause_en` at 0, a received PAUSE whose quanta is 0 leaves `hold_time_left` and `tx_hold` unchanged.
- R4: With `zero_pause_en` at 1, a received PAUSE whose quanta is 0 clears `hold_time_left` one clock later, and `tx_hold` falls one clock after that.
- R5: `tx_hold` can only rise in a cycle that follows a low `tx_frame_active`. Once it is high, it stays high while the counter is non-zero, whatever `tx_frame_active` does.
- R6: When no send episode is active, a receive FIFO level at or above `fifo_threshold` raises `pause_send_req` one clock later, with `pause_send_quanta` equal to `send_quanta`. A level below the threshold raises nothing.
- R7: `pause_send_req` and `pause_send_quanta` hold steady until `pause_send_ack` is seen. The ack drops the request one clock later and starts an outstanding-time count of `send_quanta` ticks.
- R8: With `zero_pause_en` at 1, if the level falls below the threshold while the outstanding count is non-zero, exactly one request with quanta 0 is raised. No further request follows until the level reaches the threshold again.
- R9: With `zero_pause_en` at 0, no zero-quanta request is made. Once the outstanding count has expired with the level still at or above the threshold, a new non-zero request is raised two clocks after the last tick.
- R10: After `rst` or `soft_rst`, `hold_time_left` is 0 and `tx_hold` and `pause_send_req` are low, starting with the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous soft reset, returns all state to idle |
| zero_pause_en | input | 1 | Enables handling of zero-quanta PAUSE in both directions |
| fifo_threshold | input | LVL_W | Receive FIFO level at which a PAUSE is requested |
| send_quanta | input | QUANTA_W | Quanta placed in outgoing non-zero PAUSE requests |
| quanta_tick | input | 1 | One pulse per pause quantum (512 bit times) |
| rx_pause_valid | input | 1 | Decoded PAUSE received this cycle |
| rx_pause_quanta | input | QUANTA_W | Quanta field of the received PAUSE |
| rx_fifo_level | input | LVL_W | Current receive FIFO occupancy |
| tx_frame_active | input | 1 | Transmitter is in the middle of a frame |
| tx_hold | output | 1 | Transmitter must not start a new frame |
| hold_time_left | output | QUANTA_W | Remaining receive-side hold in quanta |
| pause_send_req | output | 1 | Request to send a PAUSE frame |
| pause_send_quanta | output | QUANTA_W | Quanta for the requested PAUSE |
| pause_send_ack | input | 1 | Serialiser accepted the PAUSE request |

## Verification
The bench builds the block with `LVL_W` = 4 and the default 16-bit quanta width.

The narrow level width makes a full sweep of every FIFO level against the threshold practical. That sweep covers both sides of the boundary and the equality point. Small quanta values keep each countdown short, so every decrement of a hold can be checked one cycle at a time.

The bench also takes the send side through complete episodes with the zero-time enable at each setting, including a refresh request issued after expiry.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;
  typedef enum logic [1:0] {
    SND_IDLE   = 2'd0,
    SND_ON     = 2'd1,
    SND_PAUSED = 2'd2,
    SND_OFF    = 2'd3
  } snd_state_e;
endpackage

// File: rtl/pause_hold_timer.sv
module pause_hold_timer #(
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                zero_en,
  input  logic                tick,
  input  logic                rx_valid,
  input  logic [QUANTA_W-1:0] rx_quanta,
  output logic [QUANTA_W-1:0] time_left,
  output logic                busy
);
  localparam logic [QUANTA_W-1:0] ZERO_Q = '0;

  logic [QUANTA_W-1:0] cnt_q;
  logic                load;

  // A zero-quanta frame only counts when the enable is set; then it cancels.
  assign load = rx_valid && ((rx_quanta != ZERO_Q) || zero_en);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= ZERO_Q;
    end else if (load) begin
      cnt_q <= rx_quanta;
    end else if (tick && (cnt_q != ZERO_Q)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign time_left = cnt_q;
  assign busy      = (cnt_q != ZERO_Q);

  a_r1_load: assert property (@(posedge clk) disable iff (clr)
    (rx_valid && rx_quanta != ZERO_Q) |=> (cnt_q == $past(rx_quanta)));

  a_r3_ignore_zero: assert property (@(posedge clk) disable iff (clr)
    (rx_valid && rx_quanta == ZERO_Q && !zero_en && !tick) |=> $stable(cnt_q));

  a_r4_cancel: assert property (@(posedge clk) disable iff (clr)
    (rx_valid && rx_quanta == ZERO_Q && zero_en) |=> (cnt_q == ZERO_Q));

  a_r2_step: assert property (@(posedge clk) disable iff (clr)
    (!rx_valid && tick && cnt_q != ZERO_Q) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate (
  input  logic clk,
  input  logic clr,
  input  logic busy,
  input  logic frame_active,
  output logic tx_hold
);
  logic hold_q;

  // Rises only between frames; stays up for the rest of the hold.
  always_ff @(posedge clk) begin
    if (clr) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= busy && (hold_q || !frame_active);
    end
  end

  assign tx_hold = hold_q;

  a_r5_boundary: assert property (@(posedge clk) disable iff (clr)
    $rose(hold_q) |-> $past(!frame_active));

  a_r2_release: assert property (@(posedge clk) disable iff (clr)
    !busy |=> !hold_q);
endmodule

// File: rtl/pause_send_ctrl.sv
module pause_send_ctrl
  import pause_fc_pkg::*;
#(
  parameter int QUANTA_W = 16,
  parameter int LVL_W    = 8
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                zero_en,
  input  logic                tick,
  input  logic [LVL_W-1:0]    level,
  input  logic [LVL_W-1:0]    threshold,
  input  logic [QUANTA_W-1:0] cfg_quanta,
  input  logic                ack,
  output logic                req,
  output logic [QUANTA_W-1:0] req_quanta
);
  localparam logic [QUANTA_W-1:0] ZERO_Q = '0;

  snd_state_e          state_q;
  logic                req_q;
  logic [QUANTA_W-1:0] req_quanta_q;
  logic [QUANTA_W-1:0] peer_cnt_q;
  logic                above;

  assign above = (level >= threshold);

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q      <= SND_IDLE;
      req_q        <= 1'b0;
      req_quanta_q <= ZERO_Q;
      peer_cnt_q   <= ZERO_Q;
    end else begin
      case (state_q)
        SND_IDLE: begin
          if (above) begin
            req_q        <= 1'b1;
            req_quanta_q <= cfg_quanta;
            state_q      <= SND_ON;
          end
        end
        SND_ON: begin
          if (ack) begin
            req_q      <= 1'b0;
            peer_cnt_q <= req_quanta_q;
            state_q    <= SND_PAUSED;
          end
        end
        SND_PAUSED: begin
          if (peer_cnt_q == ZERO_Q) begin
            state_q <= SND_IDLE;
          end else if (zero_en && !above) begin
            req_q        <= 1'b1;
            req_quanta_q <= ZERO_Q;
            state_q      <= SND_OFF;
          end else if (tick) begin
            peer_cnt_q <= peer_cnt_q - 1'b1;
          end
        end
        default: begin
          if (ack) begin
            req_q      <= 1'b0;
            peer_cnt_q <= ZERO_Q;
            state_q    <= SND_IDLE;
          end
        end
      endcase
    end
  end

  assign req        = req_q;
  assign req_quanta = req_quanta_q;

  a_r7_req_stable: assert property (@(posedge clk) disable iff (clr)
    (req_q && !ack) |=> (req_q && $stable(req_quanta_q)));

  a_r7_ack_drop: assert property (@(posedge clk) disable iff (clr)
    (req_q && ack) |=> !req_q);

  a_r8_zero_needs_en: assert property (@(posedge clk) disable iff (clr)
    (state_q == SND_OFF && $past(state_q) == SND_PAUSED) |-> $past(zero_en));

  a_r6_below_quiet: assert property (@(posedge clk) disable iff (clr)
    (state_q == SND_IDLE && !above) |=> !req_q);
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int QUANTA_W = 16,
  parameter int LVL_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic                zero_pause_en,
  input  logic [LVL_W-1:0]    fifo_threshold,
  input  logic [QUANTA_W-1:0] send_quanta,
  input  logic                quanta_tick,
  input  logic                rx_pause_valid,
  input  logic [QUANTA_W-1:0] rx_pause_quanta,
  input  logic [LVL_W-1:0]    rx_fifo_level,
  input  logic                tx_frame_active,
  output logic                tx_hold,
  output logic [QUANTA_W-1:0] hold_time_left,
  output logic                pause_send_req,
  output logic [QUANTA_W-1:0] pause_send_quanta,
  input  logic                pause_send_ack
);
  logic clr;
  logic hold_busy;

  assign clr = rst || soft_rst;

  pause_hold_timer #(.QUANTA_W(QUANTA_W)) u_hold (
    .clk       (clk),
    .clr       (clr),
    .zero_en   (zero_pause_en),
    .tick      (quanta_tick),
    .rx_valid  (rx_pause_valid),
    .rx_quanta (rx_pause_quanta),
    .time_left (hold_time_left),
    .busy      (hold_busy)
  );

  pause_tx_gate u_gate (
    .clk          (clk),
    .clr          (clr),
    .busy         (hold_busy),
    .frame_active (tx_frame_active),
    .tx_hold      (tx_hold)
  );

  pause_send_ctrl #(.QUANTA_W(QUANTA_W), .LVL_W(LVL_W)) u_send (
    .clk        (clk),
    .clr        (clr),
    .zero_en    (zero_pause_en),
    .tick       (quanta_tick),
    .level      (rx_fifo_level),
    .threshold  (fifo_threshold),
    .cfg_quanta (send_quanta),
    .ack        (pause_send_ack),
    .req        (pause_send_req),
    .req_quanta (pause_send_quanta)
  );

  a_r10_clear: assert property (@(posedge clk)
    clr |=> (!tx_hold && !pause_send_req && hold_time_left == '0));
endmodule

// File: tb/test_pause_flow_ctrl.sv
module test_pause_flow_ctrl;
  localparam int QW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic          zero_pause_en = 1'b0;
  logic [LW-1:0] fifo_threshold = 4'd8;
  logic [QW-1:0] send_quanta = 16'd7;
  logic          quanta_tick = 1'b0;
  logic          rx_pause_valid = 1'b0;
  logic [QW-1:0] rx_pause_quanta = '0;
  logic [LW-1:0] rx_fifo_level = '0;
  logic          tx_frame_active = 1'b0;
  logic          pause_send_ack = 1'b0;
  logic          tx_hold;
  logic [QW-1:0] hold_time_left;
  logic          pause_send_req;
  logic [QW-1:0] pause_send_quanta;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pause_flow_ctrl #(.QUANTA_W(QW), .LVL_W(LW)) i_pause_flow_ctrl (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .zero_pause_en(zero_pause_en),
    .fifo_threshold(fifo_threshold), .send_quanta(send_quanta),
    .quanta_tick(quanta_tick), .rx_pause_valid(rx_pause_valid),
    .rx_pause_quanta(rx_pause_quanta), .rx_fifo_level(rx_fifo_level),
    .tx_frame_active(tx_frame_active), .tx_hold(tx_hold),
    .hold_time_left(hold_time_left), .pause_send_req(pause_send_req),
    .pause_send_quanta(pause_send_quanta), .pause_send_ack(pause_send_ack)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(negedge clk);
  endtask

  task automatic rx_pause(input int q);
    rx_pause_valid  = 1'b1;
    rx_pause_quanta = QW'(q);
    edge1();
    rx_pause_valid  = 1'b0;
  endtask

  task automatic do_soft();
    soft_rst = 1'b1;
    edge1();
    soft_rst = 1'b0;
  endtask

  initial begin
    edge1();
    edge1();
    rst = 1'b0;
    // R10 reset state
    chk("R10 reset tx_hold", tx_hold, 0);
    chk("R10 reset time", hold_time_left, 0);
    chk("R10 reset req", pause_send_req, 0);

    // R1 / R2 countdown sweep
    for (int q = 1; q <= 6; q++) begin
      rx_pause(q);
      chk("R1 load", hold_time_left, q);
      chk("R2 hold lag", tx_hold, 0);
      for (int i = 0; i < q; i++) begin
        quanta_tick = 1'b1;
        edge1();
        quanta_tick = 1'b0;
        chk("R2 decrement", hold_time_left, q - 1 - i);
        chk("R2 hold high", tx_hold, 1);
      end
      edge1();
      chk("R2 release", tx_hold, 0);
    end

    // R1 priority over tick and reload
    rx_pause(5);
    quanta_tick = 1'b1;
    rx_pause(9);
    quanta_tick = 1'b0;
    chk("R1 priority", hold_time_left, 9);
    rx_pause(3);
    chk("R1 reload", hold_time_left, 3);

    // R3 ignore zero with enable off
    zero_pause_en = 1'b0;
    rx_pause(0);
    chk("R3 time kept", hold_time_left, 3);
    edge1();
    chk("R3 hold kept", tx_hold, 1);

    // R4 cancel with enable on
    zero_pause_en = 1'b1;
    rx_pause(0);
    chk("R4 cancel", hold_time_left, 0);
    edge1();
    chk("R4 hold drop", tx_hold, 0);

    // R5 frame boundary
    tx_frame_active = 1'b1;
    rx_pause(4);
    edge1();
    chk("R5 wait frame", tx_hold, 0);
    edge1();
    chk("R5 still wait", tx_hold, 0);
    tx_frame_active = 1'b0;
    edge1();
    chk("R5 boundary", tx_hold, 1);
    tx_frame_active = 1'b1;
    edge1();
    chk("R5 sticky", tx_hold, 1);
    tx_frame_active = 1'b0;
    rx_pause(0);
    edge1();

    // R6 level sweep
    zero_pause_en = 1'b0;
    for (int lv = 0; lv < 16; lv++) begin
      do_soft();
      rx_fifo_level = LW'(lv);
      edge1();
      chk("R6 req vs level", pause_send_req, (lv >= 8) ? 1 : 0);
      if (lv >= 8) chk("R6 quanta", pause_send_quanta, 7);
      rx_fifo_level = '0;
    end
    do_soft();

    // R7 hold until ack
    rx_fifo_level = 4'd12;
    edge1();
    chk("R7 raised", pause_send_req, 1);
    for (int i = 0; i < 3; i++) begin
      edge1();
      chk("R7 held", pause_send_req, 1);
      chk("R7 quanta held", pause_send_quanta, 7);
    end
    pause_send_ack = 1'b1;
    edge1();
    pause_send_ack = 1'b0;
    chk("R7 ack drop", pause_send_req, 0);

    // R8 one zero-quanta request
    zero_pause_en = 1'b1;
    rx_fifo_level = 4'd3;
    edge1();
    chk("R8 zero req", pause_send_req, 1);
    chk("R8 zero quanta", pause_send_quanta, 0);
    pause_send_ack = 1'b1;
    edge1();
    pause_send_ack = 1'b0;
    chk("R8 zero ack", pause_send_req, 0);
    quanta_tick = 1'b1;
    for (int i = 0; i < 10; i++) begin
      edge1();
      chk("R8 only once", pause_send_req, 0);
    end
    quanta_tick = 1'b0;
    rx_fifo_level = 4'd12;
    edge1();
    chk("R8 new episode", pause_send_req, 1);
    chk("R8 new quanta", pause_send_quanta, 7);
    pause_send_ack = 1'b1;
    edge1();
    pause_send_ack = 1'b0;

    // R9 no zero request, refresh after expiry
    zero_pause_en = 1'b0;
    rx_fifo_level = 4'd3;
    for (int i = 0; i < 5; i++) begin
      edge1();
      chk("R9 no zero req", pause_send_req, 0);
    end
    rx_fifo_level = 4'd12;
    quanta_tick = 1'b1;
    for (int i = 0; i < 7; i++) begin
      edge1();
      chk("R9 waiting", pause_send_req, 0);
    end
    quanta_tick = 1'b0;
    edge1();
    chk("R9 idle step", pause_send_req, 0);
    edge1();
    chk("R9 refresh", pause_send_req, 1);
    chk("R9 refresh quanta", pause_send_quanta, 7);

    // R10 soft reset clears live state
    rx_pause(5);
    edge1();
    rx_fifo_level = '0;
    do_soft();
    chk("R10 soft time", hold_time_left, 0);
    chk("R10 soft hold", tx_hold, 0);
    chk("R10 soft req", pause_send_req, 0);
    edge1();
    chk("R10 stays idle", pause_send_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule